// File: doc/BRIEF.md
# Runahead Mode Controller

This controller sits next to the retirement point of a simple in-order pipeline model and looks at one retiring instruction per cycle. When the oldest instruction is a load that missed in the last-level cache, the controller asks the outside register file to take a snapshot and switches into runahead mode. While in that mode it keeps pre-executing the instructions that follow, but only to find more loads worth prefetching. Nothing executed in runahead mode is ever committed.

A per-register poison bit follows the data dependence on the missing load. An instruction that reads a poisoned register, and the missing load itself, poison their destination. Only the results that stay clean are written to the speculative copy of the register file. A load whose address register is clean sends one prefetch request through a valid/ready handshake. When the outstanding miss returns, the controller asks for the snapshot to be restored, clears every poison bit, and points execution back at the load that triggered entry.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset every output is low except `ret_ready`, which is high. `ra_active` goes high on the edge that accepts a retire slot in normal mode whose op is LOAD (`ret_op` 2'b01) and that has `ret_llc_miss` set. No other slot enters runahead mode.
- R2: Entering runahead mode raises `ckpt_save` for exactly one cycle, in the same cycle that `ra_active` first goes high.
- R3: Op codes are ALU 2'b00 (reads `ret_src_a` and `ret_src_b`, writes `ret_dst`), LOAD 2'b01 (address register `ret_src_a`, writes `ret_dst`), STORE 2'b10 and NOP 2'b11. On entry only the destination of the missing load is poisoned. In runahead mode an ALU result is poisoned if either source is poisoned. A load result is poisoned if its address register is poisoned or the load itself misses; otherwise the destination is cleaned.
- R4: A clean ALU or LOAD result accepted in runahead mode pulses `spec_we` with `spec_waddr` = destination in the next cycle. A poisoned result is dropped, with no write.
- R5: A LOAD accepted in runahead mode with a clean address register raises `pf_valid` in the next cycle, with `pf_addr` = `ret_addr`. That is one request per load.
- R6: While `pf_valid` is high and `pf_ready` is low, `pf_valid` and `pf_addr` hold and `ret_ready` is low. Otherwise `ret_ready` is high.
- R7: A LOAD in runahead mode whose address register is poisoned issues no prefetch.
- R8: In normal mode, an accepted ALU or LOAD hit pulses `arch_we`/`arch_waddr` and an accepted STORE pulses `store_commit` one cycle later. Slots accepted in runahead mode, and the triggering load, cause neither.
- R9: `miss_return` in runahead mode ends the mode at the next edge: `ra_active` falls, and `ckpt_restore` and `resume_valid` pulse for one cycle with `resume_pc` = the PC of the triggering load. All poison bits are cleared, and a slot accepted in that same cycle is dropped.
- R10: `miss_return` in normal mode has no effect.
- R11: An LLC-miss load in runahead mode takes no new snapshot and leaves `resume_pc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | Retire slot holds an instruction |
| ret_ready | output | 1 | Controller accepts the slot this cycle |
| ret_op | input | 2 | Op code (ALU/LOAD/STORE/NOP) |
| ret_dst | input | RIDX | Destination register |
| ret_src_a | input | RIDX | Source A / load address register |
| ret_src_b | input | RIDX | Source B |
| ret_llc_miss | input | 1 | Load missed in the last-level cache |
| ret_addr | input | AW | Load effective address |
| ret_pc | input | PCW | Instruction PC |
| miss_return | input | 1 | Data of the outstanding miss returned |
| ckpt_save | output | 1 | Snapshot the architectural registers |
| ckpt_restore | output | 1 | Restore the snapshot |
| arch_we | output | 1 | Architectural register write |
| arch_waddr | output | RIDX | Architectural write index |
| store_commit | output | 1 | Store commits to memory |
| spec_we | output | 1 | Speculative register write of a clean result |
| spec_waddr | output | RIDX | Speculative write index |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Prefetch request taken |
| pf_addr | output | AW | Prefetch address |
| ra_active | output | 1 | Controller is in runahead mode |
| resume_valid | output | 1 | Redirect to the resume PC |
| resume_pc | output | PCW | PC of the triggering load |

## Verification
The bench goes after the chain of poison: a clean register fed by a poisoned one, and a load whose address comes from such a register. A design that forgot to propagate poison would write that result and fire a prefetch from a garbage address. It also sends a second miss while already in runahead mode, which a wrong design would answer by re-saving the snapshot and moving `resume_pc` off the original load. A `miss_return` is driven in normal mode, where a wrong design would pulse a restore. The prefetch port is held back by `pf_ready` while retire slots keep arriving; a design that did not stall retirement there would overwrite or lose a pending request. A miss return that coincides with a retiring slot checks that the slot is dropped rather than written.

// File: rtl/ra_pkg.sv
package ra_pkg;
    typedef enum logic [1:0] {
        OP_ALU   = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_NOP   = 2'b11
    } ra_op_e;
endpackage

// File: rtl/ra_mode_fsm.sv
module ra_mode_fsm #(
    parameter int PCW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enter,
    input  logic           leave,
    input  logic [PCW-1:0] trig_pc,
    output logic           active,
    output logic           save_pulse,
    output logic           restore_pulse,
    output logic [PCW-1:0] resume_pc
);
    typedef struct packed {
        logic           active;
        logic           save;
        logic           restore;
        logic [PCW-1:0] pc;
    } mode_t;

    mode_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.save    = 1'b0;
        st_d.restore = 1'b0;
        if (st_q.active && leave) begin
            st_d.active  = 1'b0;
            st_d.restore = 1'b1;
        end else if (!st_q.active && enter) begin
            st_d.active = 1'b1;
            st_d.save   = 1'b1;
            st_d.pc     = trig_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active        = st_q.active;
    assign save_pulse    = st_q.save;
    assign restore_pulse = st_q.restore;
    assign resume_pc     = st_q.pc;

    a_r2_save_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        save_pulse |-> active && !$past(active));
    a_r9_restore_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        restore_pulse |-> !active && $past(active));
    a_r11_no_resave: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> !save_pulse && $stable(resume_pc));
    a_r2_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(save_pulse && restore_pulse));
endmodule

// File: rtl/ra_poison_track.sv
module ra_poison_track #(
    parameter int NREG = 16,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_all,
    input  logic            seed_en,
    input  logic [RIDX-1:0] seed_idx,
    input  logic            upd_en,
    input  logic [RIDX-1:0] upd_idx,
    input  logic            upd_val,
    output logic [NREG-1:0] inv
);
    logic [NREG-1:0] inv_d, inv_q;

    for (genvar g = 0; g < NREG; g++) begin : g_bit
        localparam logic [RIDX-1:0] IDX = RIDX'(g);
        always_comb begin
            if (clear_all)                      inv_d[g] = 1'b0;
            else if (seed_en)                   inv_d[g] = (seed_idx == IDX);
            else if (upd_en && upd_idx == IDX)  inv_d[g] = upd_val;
            else                                inv_d[g] = inv_q[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) inv_q <= '0;
        else        inv_q <= inv_d;
    end

    assign inv = inv_q;

    a_r3_seed_single: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_en && !clear_all) |=> $countones(inv) == 1);
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> inv == '0);
endmodule

// File: rtl/ra_prefetch_slot.sv
module ra_prefetch_slot #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [AW-1:0] issue_addr,
    input  logic          pf_ready,
    output logic          pf_valid,
    output logic [AW-1:0] pf_addr,
    output logic          free
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
    } slot_t;

    slot_t sl_d, sl_q;

    always_comb begin
        sl_d = sl_q;
        if (sl_q.vld && pf_ready) sl_d.vld = 1'b0;
        if (issue) begin
            sl_d.vld  = 1'b1;
            sl_d.addr = issue_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign pf_valid = sl_q.vld;
    assign pf_addr  = sl_q.addr;
    assign free     = !sl_q.vld || pf_ready;

    a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> pf_valid && $stable(pf_addr));
    a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> free);
endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl
    import ra_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int PCW  = 32,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ret_valid,
    output logic            ret_ready,
    input  logic [1:0]      ret_op,
    input  logic [RIDX-1:0] ret_dst,
    input  logic [RIDX-1:0] ret_src_a,
    input  logic [RIDX-1:0] ret_src_b,
    input  logic            ret_llc_miss,
    input  logic [AW-1:0]   ret_addr,
    input  logic [PCW-1:0]  ret_pc,
    input  logic            miss_return,
    output logic            ckpt_save,
    output logic            ckpt_restore,
    output logic            arch_we,
    output logic [RIDX-1:0] arch_waddr,
    output logic            store_commit,
    output logic            spec_we,
    output logic [RIDX-1:0] spec_waddr,
    output logic            pf_valid,
    input  logic            pf_ready,
    output logic [AW-1:0]   pf_addr,
    output logic            ra_active,
    output logic            resume_valid,
    output logic [PCW-1:0]  resume_pc
);
    typedef struct packed {
        logic            arch_we;
        logic [RIDX-1:0] arch_waddr;
        logic            store_commit;
        logic            spec_we;
        logic [RIDX-1:0] spec_waddr;
    } wb_t;

    wb_t             wb_d, wb_q;
    logic [NREG-1:0] inv;
    logic            pf_free, accept, leave, enter, spec_slot;
    logic            a_bad, b_bad, upd_en, upd_val, pf_issue;
    ra_op_e          op;

    assign op        = ra_op_e'(ret_op);
    assign ret_ready = pf_free;
    assign accept    = ret_valid && pf_free;
    assign leave     = ra_active && miss_return;
    assign enter     = !ra_active && accept && op == OP_LOAD && ret_llc_miss;
    assign spec_slot = ra_active && !leave && accept;
    assign a_bad     = inv[ret_src_a];
    assign b_bad     = inv[ret_src_b];

    always_comb begin
        wb_d     = '0;
        upd_en   = 1'b0;
        upd_val  = 1'b0;
        pf_issue = 1'b0;
        if (!ra_active && accept) begin
            unique case (op)
                OP_ALU: begin
                    wb_d.arch_we    = 1'b1;
                    wb_d.arch_waddr = ret_dst;
                end
                OP_LOAD: begin
                    wb_d.arch_we    = !ret_llc_miss;
                    wb_d.arch_waddr = ret_dst;
                end
                OP_STORE: wb_d.store_commit = 1'b1;
                default: ;
            endcase
        end
        if (spec_slot) begin
            unique case (op)
                OP_ALU: begin
                    upd_en  = 1'b1;
                    upd_val = a_bad || b_bad;
                end
                OP_LOAD: begin
                    upd_en   = 1'b1;
                    upd_val  = a_bad || ret_llc_miss;
                    pf_issue = !a_bad;
                end
                default: ;
            endcase
            wb_d.spec_we    = upd_en && !upd_val;
            wb_d.spec_waddr = ret_dst;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    ra_mode_fsm #(.PCW(PCW)) u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .enter         (enter),
        .leave         (leave),
        .trig_pc       (ret_pc),
        .active        (ra_active),
        .save_pulse    (ckpt_save),
        .restore_pulse (ckpt_restore),
        .resume_pc     (resume_pc)
    );

    ra_poison_track #(.NREG(NREG)) u_poison (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (leave),
        .seed_en   (enter),
        .seed_idx  (ret_dst),
        .upd_en    (upd_en),
        .upd_idx   (ret_dst),
        .upd_val   (upd_val),
        .inv       (inv)
    );

    ra_prefetch_slot #(.AW(AW)) u_pf (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (pf_issue),
        .issue_addr (ret_addr),
        .pf_ready   (pf_ready),
        .pf_valid   (pf_valid),
        .pf_addr    (pf_addr),
        .free       (pf_free)
    );

    assign arch_we      = wb_q.arch_we;
    assign arch_waddr   = wb_q.arch_waddr;
    assign store_commit = wb_q.store_commit;
    assign spec_we      = wb_q.spec_we;
    assign spec_waddr   = wb_q.spec_waddr;
    assign resume_valid = ckpt_restore;

    a_r8_no_commit_in_ra: assert property (@(posedge clk) disable iff (!rst_n)
        ra_active |-> !arch_we && !store_commit);
    a_r4_spec_only_in_ra: assert property (@(posedge clk) disable iff (!rst_n)
        spec_we |-> ra_active);
    a_r10_stale_return: assert property (@(posedge clk) disable iff (!rst_n)
        (!ra_active && miss_return) |=> !ckpt_restore);
    a_r6_stall_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |-> !ret_ready);
endmodule

// File: tb/runahead_ctrl_tb.sv
module runahead_ctrl_tb;
    localparam int NREG = 16;
    localparam int AW   = 32;
    localparam int PCW  = 32;
    localparam int RIDX = $clog2(NREG);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic            ret_valid = 0, ret_llc_miss = 0, miss_return = 0, pf_ready = 1;
    logic [1:0]      ret_op = 0;
    logic [RIDX-1:0] ret_dst = 0, ret_src_a = 0, ret_src_b = 0;
    logic [AW-1:0]   ret_addr = 0;
    logic [PCW-1:0]  ret_pc = 0;
    logic            ret_ready, ckpt_save, ckpt_restore, arch_we, store_commit;
    logic            spec_we, pf_valid, ra_active, resume_valid;
    logic [RIDX-1:0] arch_waddr, spec_waddr;
    logic [AW-1:0]   pf_addr;
    logic [PCW-1:0]  resume_pc;

    runahead_ctrl #(.NREG(NREG), .AW(AW), .PCW(PCW)) u_dut (.*);

    int n_chk = 0, n_bad = 0;

    // reference state
    logic            m_ra = 0, m_pfv = 0;
    logic [NREG-1:0] m_inv = '0;
    logic [PCW-1:0]  m_pc = '0;
    logic [AW-1:0]   m_pfa = '0;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_ready(input logic rdy);
        return !m_pfv || rdy;
    endfunction

    task automatic step(input logic v, input logic [1:0] op, input logic [RIDX-1:0] d, a, b,
                        input logic miss, input logic [AW-1:0] addr, input logic [PCW-1:0] pc,
                        input logic mr, input logic rdy);
        logic acc, lv, en, sp, ab, bb, e_arch, e_st, e_spec, e_save, e_rest, iss, pv_n, pbad;
        logic [AW-1:0] pa_n;
        logic [NREG-1:0] inv_n;
        logic [PCW-1:0] pc_n;
        ret_valid = v; ret_op = op; ret_dst = d; ret_src_a = a; ret_src_b = b;
        ret_llc_miss = miss; ret_addr = addr; ret_pc = pc; miss_return = mr; pf_ready = rdy;
        #1;
        chk(ret_ready == exp_ready(rdy), "R6 ret_ready", 64'(ret_ready), 64'(exp_ready(rdy)));
        acc = v && exp_ready(rdy);
        lv  = m_ra && mr;
        en  = !m_ra && acc && op == 2'b01 && miss;
        sp  = m_ra && !lv && acc;
        ab  = m_inv[a]; bb = m_inv[b];
        e_arch = !m_ra && acc && (op == 2'b00 || (op == 2'b01 && !miss));
        e_st   = !m_ra && acc && op == 2'b10;
        e_spec = 0; iss = 0; pbad = 0;
        inv_n = m_inv; pc_n = m_pc;
        e_save = en; e_rest = lv;
        if (lv) inv_n = '0;
        else if (en) begin inv_n = '0; inv_n[d] = 1'b1; pc_n = pc; end
        else if (sp && op == 2'b00) begin inv_n[d] = ab | bb; e_spec = !(ab | bb); end
        else if (sp && op == 2'b01) begin
            inv_n[d] = ab | miss; e_spec = !(ab | miss); iss = !ab; pbad = ab;
        end
        pv_n = m_pfv && !rdy; pa_n = m_pfa;
        if (iss) begin pv_n = 1; pa_n = addr; end
        @(posedge clk); #1;
        chk(ra_active == (en || (m_ra && !lv)), (mr && !m_ra) ? "R10 ra_active" : "R1 ra_active",
            64'(ra_active), 64'(en || (m_ra && !lv)));
        chk(ckpt_save == e_save, (m_ra && miss) ? "R11 ckpt_save" : "R2 ckpt_save", 64'(ckpt_save), 64'(e_save));
        chk(ckpt_restore == e_rest && resume_valid == e_rest, mr && !m_ra ? "R10 restore" : "R9 restore",
            64'(ckpt_restore), 64'(e_rest));
        if (e_rest) chk(resume_pc == m_pc, "R9 resume_pc", 64'(resume_pc), 64'(m_pc));
        chk(resume_pc == pc_n, "R11 resume_pc", 64'(resume_pc), 64'(pc_n));
        chk(arch_we == e_arch && (!e_arch || arch_waddr == d), "R8 arch_we", 64'(arch_we), 64'(e_arch));
        chk(store_commit == e_st, "R8 store_commit", 64'(store_commit), 64'(e_st));
        chk(spec_we == e_spec && (!e_spec || spec_waddr == d), "R3 R4 spec_we", 64'(spec_we), 64'(e_spec));
        chk(pf_valid == pv_n, pbad ? "R7 pf_valid" : "R5 pf_valid", 64'(pf_valid), 64'(pv_n));
        if (pv_n) chk(pf_addr == pa_n, "R6 pf_addr", 64'(pf_addr), 64'(pa_n));
        m_ra = en || (m_ra && !lv); m_inv = inv_n; m_pc = pc_n; m_pfv = pv_n; m_pfa = pa_n;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk({ra_active, ckpt_save, ckpt_restore, arch_we, store_commit, spec_we, pf_valid, resume_valid} == 8'h0 && ret_ready,
            "R1 reset", 64'({ra_active, pf_valid, spec_we}), 64'h0);
        @(negedge clk);
        // normal mode work
        step(1, 2'b00, 4'd1, 4'd2, 4'd3, 0, 32'h0,   32'h10, 0, 1); // R8 ALU
        step(1, 2'b10, 4'd0, 4'd2, 4'd3, 0, 32'h40,  32'h14, 0, 1); // R8 store
        step(1, 2'b01, 4'd4, 4'd2, 4'd0, 0, 32'h80,  32'h18, 1, 1); // R10 stale return + hit load
        step(0, 2'b11, 4'd0, 4'd0, 4'd0, 0, 32'h0,   32'h1c, 1, 1); // R10
        // R1 R2 entry on miss load, dst r3
        step(1, 2'b01, 4'd3, 4'd2, 4'd0, 1, 32'h100, 32'h100, 0, 1);
        step(1, 2'b00, 4'd5, 4'd3, 4'd1, 0, 32'h0,   32'h104, 0, 1); // R3 poisoned r5
        step(1, 2'b00, 4'd6, 4'd1, 4'd2, 0, 32'h0,   32'h108, 0, 1); // R4 clean r6
        step(1, 2'b01, 4'd7, 4'd5, 4'd0, 0, 32'h200, 32'h10c, 0, 1); // R7 no prefetch
        step(1, 2'b01, 4'd8, 4'd1, 4'd0, 0, 32'h300, 32'h110, 0, 0); // R5 prefetch
        step(1, 2'b00, 4'd9, 4'd1, 4'd1, 0, 32'h0,   32'h114, 0, 0); // R6 stalled
        step(1, 2'b00, 4'd9, 4'd1, 4'd1, 0, 32'h0,   32'h114, 0, 1); // R6 drain
        step(1, 2'b01, 4'd1, 4'd2, 4'd0, 1, 32'h400, 32'h118, 0, 1); // R11 second miss
        step(1, 2'b10, 4'd0, 4'd2, 4'd3, 0, 32'h44,  32'h11c, 0, 1); // R8 store dropped
        step(1, 2'b00, 4'd2, 4'd6, 4'd6, 0, 32'h0,   32'h120, 1, 1); // R9 exit, slot dropped
        step(1, 2'b00, 4'd2, 4'd3, 4'd3, 0, 32'h0,   32'h100, 0, 1); // R9 back to normal
        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] op;
            logic miss, mr, rdy;
            op   = 2'($urandom_range(0, 3));
            miss = ($urandom_range(0, 3) == 0);
            mr   = m_ra ? ($urandom_range(0, 15) == 0) : ($urandom_range(0, 31) == 0);
            rdy  = ($urandom_range(0, 2) != 0);
            step($urandom_range(0, 4) != 0, op, 4'($urandom), 4'($urandom), 4'($urandom),
                 miss, $urandom, $urandom, mr, rdy);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule